// File: doc/BRIEF.md
# Program Counter and Control-Flow Sequencer

This block owns the 16-bit program counter and the 16-bit stack pointer of a small 8-bit processor core and carries out every change of control flow. An external decoder presents one command per cycle together with the operands it has already gathered. These are a 16-bit target, a signed 8-bit displacement, the current HL register pair, a three-bit condition selector and the zero and carry flags. The block then steps, loads or offsets the program counter.

Calls and returns move the return address through the stack in memory. The memory port is one byte wide, so each push or pop takes two byte transfers. While a transfer sequence runs, a busy output is high and further commands are dropped. A return variant also sets a sticky interrupt-enable output. Operand bytes are fetched with the step command before a jump command is issued. A jump, call or return whose condition fails therefore leaves the counter where it already is, which is just past the operands.

Top module: `pc_branch_seq`

## Requirements
- R1: After reset the program counter is 0x0100, the stack pointer is 0xFFFE, busy and the interrupt-enable output are low, and neither memory strobe is active.
- R2: Command code 1 (step) adds one to the program counter in the next cycle, wrapping from 0xFFFF to 0x0000.
- R3: Command code 2 loads the 16-bit target into the program counter when the condition holds. Command code 3 loads the program counter from HL unconditionally.
- R4: Command code 4 adds the sign-extended 8-bit displacement to the program counter when the condition holds, wrapping modulo 2^16.
- R5: The condition selector has two cases. If bit 2 is 0, the condition always holds. If bit 2 is 1, bits 1:0 choose the test: 00 zero clear, 01 zero set, 10 carry clear, 11 carry set. A failed condition leaves the program counter and stack pointer unchanged, performs no memory access and does not raise busy.
- R6: Command code 5 (call), when taken, runs two busy cycles. The first writes the high byte of the program counter to SP-1. The second writes the low byte to SP-2. The stack pointer ends at SP-2 and the program counter becomes the target.
- R7: Command code 6 (return), when taken, runs three busy cycles. It reads the low byte at SP and then the high byte at SP+1. Read data is expected one cycle after the read strobe. The program counter becomes {high, low} and the stack pointer ends at SP+2.
- R8: Command code 7 is an unconditional return that also sets the interrupt-enable output once the pop completes. The output then stays high until reset. A plain return leaves it unchanged.
- R9: Command code 8 loads the stack pointer from HL.
- R10: A command presented while busy is high has no effect on the program counter, the stack pointer or the memory port.
- R11: The write and read strobes are never high together, and neither is high while busy is low.
- R12: Command code 0 and codes 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 4 | Control-flow command code |
| cond | input | 3 | Condition selector |
| imm16 | input | 16 | Absolute target address |
| rel8 | input | 8 | Signed displacement |
| hl | input | 16 | HL register pair value |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Push or pop sequence in progress |
| ie | output | 1 | Interrupt enable |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read byte, valid the cycle after mem_re |

## Verification
The hardest case to reach from the ports is a command that arrives in the middle of a push or pop. In normal use the decoder never issues one, yet a leak would corrupt the program counter or the stack. The stimulus reaches it by holding a conflicting absolute jump on the command port for every busy cycle of calls and returns, in both directed and random runs. It releases that jump in the same half-cycle that busy falls. Returns are also taken from stack areas filled with random bytes, so that a swap of high and low bytes shows up in the result.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_FETCH = 4'd1,
    CMD_JP    = 4'd2,
    CMD_JPHL  = 4'd3,
    CMD_JR    = 4'd4,
    CMD_CALL  = 4'd5,
    CMD_RET   = 4'd6,
    CMD_RETI  = 4'd7,
    CMD_LDSP  = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_POP_LO, ST_POP_HI, ST_POP_FIN
  } seq_st_e;

  // Condition test: bit 2 low means unconditional
  function automatic logic cond_holds(input logic [2:0] cc, input logic z, input logic c);
    logic r;
    if (!cc[2]) r = 1'b1;
    else begin
      case (cc[1:0])
        2'b00:   r = !z;
        2'b01:   r = z;
        2'b10:   r = !c;
        default: r = c;
      endcase
    end
    return r;
  endfunction

  // Relative target: sign-extended displacement added modulo 2^16
  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] base,
                                                   input logic [BYTE_W-1:0] off);
    return base + {{(ADDR_W-BYTE_W){off[BYTE_W-1]}}, off};
  endfunction
endpackage

// File: rtl/pcseq_cond_eval.sv
`timescale 1ns/1ps
module pcseq_cond_eval
  import pcseq_pkg::*;
(
  input  logic [2:0] cond,
  input  logic       flag_z,
  input  logic       flag_c,
  output logic       taken
);
  assign taken = cond_holds(cond, flag_z, flag_c);
endmodule

// File: rtl/pcseq_pc_unit.sv
`timescale 1ns/1ps
module pcseq_pc_unit
  import pcseq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              ld_abs,
  input  logic [ADDR_W-1:0] abs_val,
  input  logic              ld_rel,
  input  logic [BYTE_W-1:0] rel_off,
  input  logic              cap_call,
  input  logic              ld_call,
  input  logic              ld_stack,
  input  logic [ADDR_W-1:0] stack_val,
  output logic [ADDR_W-1:0] pc
);
  logic [ADDR_W-1:0] pc_q, pc_d, call_tgt_q;

  always_comb begin
    pc_d = pc_q;
    if (ld_stack)     pc_d = stack_val;
    else if (ld_call) pc_d = call_tgt_q;
    else if (ld_abs)  pc_d = abs_val;
    else if (ld_rel)  pc_d = rel_target(pc_q, rel_off);
    else if (inc)     pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= RESET_PC;
      call_tgt_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (cap_call) call_tgt_q <= abs_val;
    end
  end

  assign pc = pc_q;

  // R2: a lone step advances by exactly one
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_stack && !ld_call && !ld_abs && !ld_rel) |=> pc_q == $past(pc_q) + 16'd1);

  // R4: relative move lands at old PC plus signed displacement
  a_r4_rel_move: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rel && !ld_stack && !ld_call && !ld_abs) |=>
      $signed(pc_q - $past(pc_q)) == $signed({{8{$past(rel_off[7])}}, $past(rel_off)}));

  // R6: the end of a push installs the captured call target
  a_r6_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_call && !ld_stack) |=> pc_q == $past(call_tgt_q));
endmodule

// File: rtl/pcseq_stack_seq.sv
`timescale 1ns/1ps
module pcseq_stack_seq
  import pcseq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_SP = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_push,
  input  logic              start_pop,
  input  logic              pop_sets_ie,
  input  logic              ld_sp,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              ie,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              push_done,
  output logic              pop_done,
  output logic [ADDR_W-1:0] pop_val
);
  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [BYTE_W-1:0] lo_q;
  logic              ie_q, reti_q;

  always_comb begin
    st_d = st_q;
    sp_d = sp_q;
    case (st_q)
      ST_IDLE: begin
        if (start_push)     st_d = ST_PUSH_HI;
        else if (start_pop) st_d = ST_POP_LO;
        else if (ld_sp)     sp_d = sp_val;
      end
      ST_PUSH_HI: begin sp_d = sp_q - 1'b1; st_d = ST_PUSH_LO; end
      ST_PUSH_LO: begin sp_d = sp_q - 1'b1; st_d = ST_IDLE;    end
      ST_POP_LO:  begin sp_d = sp_q + 1'b1; st_d = ST_POP_HI;  end
      ST_POP_HI:  begin sp_d = sp_q + 1'b1; st_d = ST_POP_FIN; end
      ST_POP_FIN: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sp_q   <= RESET_SP;
      lo_q   <= '0;
      ie_q   <= 1'b0;
      reti_q <= 1'b0;
    end else begin
      st_q <= st_d;
      sp_q <= sp_d;
      if (st_q == ST_IDLE && start_pop) reti_q <= pop_sets_ie;
      if (st_q == ST_POP_HI)            lo_q   <= mem_rdata;
      if (st_q == ST_POP_FIN && reti_q) ie_q   <= 1'b1;
    end
  end

  assign mem_we    = (st_q == ST_PUSH_HI) || (st_q == ST_PUSH_LO);
  assign mem_re    = (st_q == ST_POP_LO)  || (st_q == ST_POP_HI);
  assign mem_addr  = mem_we ? sp_q - 1'b1 : sp_q;
  assign mem_wdata = (st_q == ST_PUSH_HI) ? ret_addr[ADDR_W-1:BYTE_W] : ret_addr[BYTE_W-1:0];
  assign push_done = (st_q == ST_PUSH_LO);
  assign pop_done  = (st_q == ST_POP_FIN);
  assign pop_val   = {mem_rdata, lo_q};
  assign busy      = (st_q != ST_IDLE);
  assign sp        = sp_q;
  assign ie        = ie_q;

  // R6: the second push byte goes one address below the first
  a_r6_push_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH_HI) |=> mem_we && mem_addr == $past(mem_addr) - 16'd1);

  // R7: the second pop byte comes from one address above the first
  a_r7_pop_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POP_LO) |=> mem_re && mem_addr == $past(mem_addr) + 16'd1);

  // R8: interrupt enable never drops once set
  a_r8_ie_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q |=> ie_q);

  // R9: an idle stack-pointer load takes the HL value
  a_r9_sp_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && ld_sp && !start_push && !start_pop) |=> sp_q == $past(sp_val));

  // R11: one strobe at a time
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: rtl/pc_branch_seq.sv
`timescale 1ns/1ps
module pc_branch_seq
  import pcseq_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0100,
  parameter logic [15:0] RESET_SP = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cmd,
  input  logic [2:0]  cond,
  input  logic [15:0] imm16,
  input  logic [7:0]  rel8,
  input  logic [15:0] hl,
  input  logic        flag_z,
  input  logic        flag_c,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic        busy,
  output logic        ie,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata
);
  logic        taken, accept;
  logic        do_inc, do_jp, do_jphl, do_jr, do_call, do_pop, do_reti, do_ldsp;
  logic        push_done, pop_done, pc_load_evt, cond_skip;
  logic [15:0] abs_val, pop_val;

  pcseq_cond_eval u_cond (
    .cond(cond), .flag_z(flag_z), .flag_c(flag_c), .taken(taken)
  );

  // Commands are only acted on while no stack sequence runs
  assign accept  = !busy;
  assign do_inc  = accept && (cmd == CMD_FETCH);
  assign do_jp   = accept && (cmd == CMD_JP)   && taken;
  assign do_jphl = accept && (cmd == CMD_JPHL);
  assign do_jr   = accept && (cmd == CMD_JR)   && taken;
  assign do_call = accept && (cmd == CMD_CALL) && taken;
  assign do_reti = accept && (cmd == CMD_RETI);
  assign do_pop  = (accept && (cmd == CMD_RET) && taken) || do_reti;
  assign do_ldsp = accept && (cmd == CMD_LDSP);
  assign abs_val = do_jphl ? hl : imm16;

  assign cond_skip = accept && !taken &&
                     ((cmd == CMD_JP) || (cmd == CMD_JR) || (cmd == CMD_CALL) || (cmd == CMD_RET));
  assign pc_load_evt = push_done || pop_done;

  pcseq_pc_unit #(.RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n),
    .inc(do_inc),
    .ld_abs(do_jp || do_jphl), .abs_val(abs_val),
    .ld_rel(do_jr), .rel_off(rel8),
    .cap_call(do_call), .ld_call(push_done),
    .ld_stack(pop_done), .stack_val(pop_val),
    .pc(pc)
  );

  pcseq_stack_seq #(.RESET_SP(RESET_SP)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .start_push(do_call), .start_pop(do_pop), .pop_sets_ie(do_reti),
    .ld_sp(do_ldsp), .sp_val(hl),
    .ret_addr(pc), .mem_rdata(mem_rdata),
    .sp(sp), .busy(busy), .ie(ie),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .push_done(push_done), .pop_done(pop_done), .pop_val(pop_val)
  );

  // R10: the counter holds during a sequence until its final load
  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_load_evt) |=> $stable(pc));

  // R5: a failed condition moves nothing and starts no sequence
  a_r5_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cond_skip |=> !busy && $stable(pc) && $stable(sp));

  // R11: strobes only inside a sequence
  a_r11_strobe_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !mem_re);

  // R12: unused codes leave state untouched
  a_r12_nop_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cmd == CMD_NOP || cmd > CMD_LDSP)) |=> $stable(pc) && $stable(sp) && !busy);
endmodule

// File: tb/pc_branch_seq_test.sv
`timescale 1ns/1ps
module pc_branch_seq_test;
  import pcseq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd = 4'd0;
  logic [2:0]  cond = 3'd0;
  logic [15:0] imm16 = 16'd0, hl = 16'd0;
  logic [7:0]  rel8 = 8'd0;
  logic        flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] pc, sp, mem_addr;
  logic        busy, ie, mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem [0:255];
  logic [7:0]  rd_q = 8'd0;
  logic        pre_we = 1'b0;
  logic [7:0]  pre_addr = 8'd0, pre_data = 8'd0;

  int nchk = 0, nerr = 0, viol = 0;
  logic [15:0] m_pc, m_sp;
  logic        m_ie;

  always #2.5 clk = ~clk;

  pc_branch_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cond(cond), .imm16(imm16), .rel8(rel8),
    .hl(hl), .flag_z(flag_z), .flag_c(flag_c), .pc(pc), .sp(sp), .busy(busy), .ie(ie),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  // Byte memory model, 256 bytes indexed by the low address byte
  always_ff @(posedge clk) begin
    if (pre_we)      mem[pre_addr] <= pre_data;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re)      rd_q <= mem[mem_addr[7:0]];
  end
  assign mem_rdata = rd_q;

  // R11 port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && mem_re) viol++;
      if (!busy && (mem_we || mem_re)) viol++;
    end
  end

  function automatic bit exp_cond(input logic [2:0] cc, input logic z, input logic c);
    case (cc)
      3'b100:  return z == 1'b0;
      3'b101:  return z == 1'b1;
      3'b110:  return c == 1'b0;
      3'b111:  return c == 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] exp_rel(input logic [15:0] p, input logic [7:0] d);
    int s;
    s = int'(p) + int'($signed(d));
    return 16'(s & 32'hFFFF);
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd1: return "R2 step";
      4'd2: return "R3 jump";
      4'd3: return "R3 jump-hl";
      4'd4: return "R4 relative";
      4'd5: return "R6 call";
      4'd6: return "R7 return";
      4'd7: return "R8 return-ie";
      4'd8: return "R9 sp-load";
      default: return "R12 no-op code";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic do_op(input logic [3:0] c, input logic [2:0] cc, input logic [15:0] im,
                       input logic [7:0] rl, input logic [15:0] h, input logic z,
                       input logic cf, input bit intrude, input string tag);
    logic [15:0] e_pc, e_sp, ret;
    logic        e_ie;
    int          e_busy, n;
    bit          tk;
    e_pc = m_pc; e_sp = m_sp; e_ie = m_ie; e_busy = 0; ret = m_pc;
    tk = exp_cond(cc, z, cf);
    case (c)
      4'd1: e_pc = m_pc + 16'd1;
      4'd2: if (tk) e_pc = im;
      4'd3: e_pc = h;
      4'd4: if (tk) e_pc = exp_rel(m_pc, rl);
      4'd5: if (tk) begin e_sp = m_sp - 16'd2; e_pc = im; e_busy = 2; end
      4'd6, 4'd7: if (tk || c == 4'd7) begin
        e_pc = {mem[8'(m_sp + 16'd1)], mem[m_sp[7:0]]};
        e_sp = m_sp + 16'd2; e_busy = 3;
        if (c == 4'd7) e_ie = 1'b1;
      end
      4'd8: e_sp = h;
      default: ;
    endcase
    @(negedge clk);
    cmd = c; cond = cc; imm16 = im; rel8 = rl; hl = h; flag_z = z; flag_c = cf;
    @(negedge clk);
    if (intrude) begin cmd = 4'd2; cond = 3'd0; imm16 = 16'hDEAD; hl = 16'hBEEF; end
    else cmd = 4'd0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    cmd = 4'd0;
    chk(pc == e_pc, {tag, " pc"}, 32'(pc), 32'(e_pc));
    chk(sp == e_sp, {tag, " sp"}, 32'(sp), 32'(e_sp));
    chk(ie == e_ie, {tag, " ie"}, 32'(ie), 32'(e_ie));
    chk(n == e_busy, {tag, " busy cycles"}, 32'(n), 32'(e_busy));
    if (c == 4'd5 && tk)
      chk({mem[8'(e_sp + 16'd1)], mem[e_sp[7:0]]} == ret, "R6 pushed bytes",
          32'({mem[8'(e_sp + 16'd1)], mem[e_sp[7:0]]}), 32'(ret));
    m_pc = e_pc; m_sp = e_sp; m_ie = e_ie;
  endtask

  task automatic run_all();
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) preload(8'(i), 8'($urandom));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pc == 16'h0100, "R1 reset pc", 32'(pc), 32'h0100);
    chk(sp == 16'hFFFE, "R1 reset sp", 32'(sp), 32'hFFFE);
    chk(!busy && !ie, "R1 reset busy/ie", {30'd0, busy, ie}, 32'd0);
    chk(!mem_we && !mem_re, "R1 reset strobes", {30'd0, mem_we, mem_re}, 32'd0);
    m_pc = 16'h0100; m_sp = 16'hFFFE; m_ie = 1'b0;

    do_op(4'd1, 3'd0, 16'h0, 8'h0, 16'h0, 0, 0, 0, "R2 step");
    do_op(4'd2, 3'd0, 16'hFFFF, 8'h0, 16'h0, 0, 0, 0, "R3 jump");
    do_op(4'd1, 3'd0, 16'h0, 8'h0, 16'h0, 0, 0, 0, "R2 step wrap");
    do_op(4'd3, 3'd0, 16'h0, 8'h0, 16'h4000, 0, 0, 0, "R3 jump-hl");
    do_op(4'd4, 3'd0, 16'h0, 8'h80, 16'h0, 0, 0, 0, "R4 relative -128");
    do_op(4'd4, 3'd0, 16'h0, 8'h7F, 16'h0, 0, 0, 0, "R4 relative +127");
    do_op(4'd3, 3'd0, 16'h0, 8'h0, 16'h0005, 0, 0, 0, "R3 jump-hl low");
    do_op(4'd4, 3'd0, 16'h0, 8'hF0, 16'h0, 0, 0, 0, "R4 relative wrap");
    // R5: each test once failing and once passing
    do_op(4'd2, 3'b100, 16'h1111, 8'h0, 16'h0, 1, 0, 0, "R5 zero-clear fails");
    do_op(4'd2, 3'b100, 16'h1111, 8'h0, 16'h0, 0, 1, 0, "R5 zero-clear holds");
    do_op(4'd4, 3'b101, 16'h0, 8'h10, 16'h0, 0, 1, 0, "R5 zero-set fails");
    do_op(4'd5, 3'b110, 16'h2222, 8'h0, 16'h0, 1, 1, 0, "R5 carry-clear call fails");
    do_op(4'd6, 3'b111, 16'h0, 8'h0, 16'h0, 1, 0, 0, "R5 carry-set return fails");
    do_op(4'd8, 3'd0, 16'h0, 8'h0, 16'hFF80, 0, 0, 0, "R9 sp-load");
    do_op(4'd5, 3'b111, 16'h3456, 8'h0, 16'h0, 0, 1, 0, "R6 call");
    do_op(4'd5, 3'd0, 16'h789A, 8'h0, 16'h0, 0, 0, 1, "R10 call with intruder");
    do_op(4'd6, 3'b101, 16'h0, 8'h0, 16'h0, 1, 0, 1, "R10 return with intruder");
    do_op(4'd6, 3'd0, 16'h0, 8'h0, 16'h0, 0, 0, 0, "R7 return");
    do_op(4'd0, 3'd0, 16'h5555, 8'h0, 16'h5555, 0, 0, 0, "R12 nop");
    do_op(4'd11, 3'd0, 16'h5555, 8'h0, 16'h5555, 0, 0, 0, "R12 code 11");
    do_op(4'd15, 3'd0, 16'h5555, 8'h0, 16'h5555, 0, 0, 0, "R12 code 15");
    do_op(4'd7, 3'b100, 16'h0, 8'h0, 16'h0, 1, 0, 0, "R8 return-ie");
    do_op(4'd6, 3'd0, 16'h0, 8'h0, 16'h0, 0, 0, 0, "R8 ie stays after return");

    for (int i = 0; i < 600; i++) begin
      logic [3:0] c;
      logic [15:0] h;
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 8: c = 4'd1;
        1: c = 4'd2;
        2: c = 4'd3;
        3: c = 4'd4;
        4: c = 4'd5;
        5: c = 4'd6;
        6: c = 4'd7;
        7: c = 4'd8;
        default: c = 4'($urandom_range(9, 15));
      endcase
      h = (c == 4'd8) ? {8'hFF, 8'($urandom)} : 16'($urandom);
      do_op(c, 3'($urandom), 16'($urandom), 8'($urandom), h,
            1'($urandom), 1'($urandom), 1'($urandom), tag_of(c));
    end
    chk(viol == 0, "R11 strobe rules", 32'(viol), 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R10 watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule